// File: doc/BRIEF.md
# Three-Phase Commutation PWM Generator

This block drives the six bridge pins of a brushless DC motor: a true and a complementary pin for each of the phases U, V and W. A single up-counting period counter serves all three phases. Each phase compares the counter against its own duty value to form a PWM signal. Each pin either follows its phase's PWM signal or drives a fixed level. An active-level bit per pin then sets the pin's polarity.

The cycle and duty values have write buffers, and so do the per-pin state-select and level-data patterns. While the counter is stopped, a write goes to the buffer and to the live register in the same clock. While it runs, new cycle and duty values take effect at the period boundary. A new pin pattern takes effect only on a commutation strobe, which comes either from an external compare event or from software, so all six pins switch in the same clock. The block raises an interrupt request on each period match when that request is enabled. An inactivate input forces every pin to its inactive level.

Top module: `bldc_pattern_gen`

## Requirements
- R1: After reset, every pin reads 0 and irq reads 0. All active-level bits reset to 1, and the cycle, duty, pattern and interrupt-enable registers reset to 0.
- R2: While run is 1, the counter counts up from 0 to the live cycle value and returns to 0 on the next clock, so one period lasts cycle+1 clocks. While run is 0, the counter is held at 0.
- R3: A phase's PWM signal is active while the counter is below that phase's live duty. A duty of 0 never activates it, and a duty greater than the cycle keeps it active for the whole period.
- R4: Pin index i is ordered 0=U, 1=UB, 2=V, 3=VB, 4=W, 5=WB, and pin i belongs to phase i/2. When state-select bit i is 0, the pin's internal active signal is its phase's PWM signal. When the bit is 1, the active signal is level-data bit i (0 low, 1 high).
- R5: When active-level bit i is 1, pin i equals its active signal. When the bit is 0, pin i is the inverse of its active signal. The inactive level of pin i is the inverse of active-level bit i.
- R6: While run is 0, every pin is at its inactive level. A write to any buffered register is copied into the live register on the same clock edge.
- R7: While run is 1, writes to the cycle and duty buffers change nothing until the period boundary (counter equal to the cycle). At that edge the buffers become live.
- R8: While run is 1, the live state-select and level-data patterns change only on a clock where cmt_ext or cmt_sw is 1. The strobe copies both pattern buffers at once. A buffer write in the same clock as the strobe is not part of that commit.
- R9: irq is 1 in exactly the clocks where run is 1, the counter equals the live cycle and the interrupt enable bit is 1.
- R10: While kill is 1, every pin is at its inactive level, whatever its mode, data or PWM state.
- R11: Write addresses: 0 cycle buffer, 1/2/3 duty buffers U/V/W, 4 state-select buffer (bits 5:0), 5 level-data buffer (bits 5:0), 6 active-level bits (bits 5:0, not buffered), 7 interrupt enable (bit 0, not buffered).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CW | Register write data |
| run | input | 1 | 1 runs the period counter, 0 stops it |
| cmt_ext | input | 1 | Commutation strobe from an external compare match |
| cmt_sw | input | 1 | Commutation strobe from software |
| kill | input | 1 | Forces all pins inactive |
| pins | output | 6 | Bridge pins U, UB, V, VB, W, WB (bit 0 to 5) |
| irq | output | 1 | Period-match interrupt request |

## Verification
Two functions can fall in the same clock: a pattern-buffer write and a commutation strobe, and also a cycle or duty buffer write and the period boundary. The bench provokes both by issuing the write in the very clock that carries the strobe or the counter match. It judges the outcome against a cycle-level reference model built from the requirements. In that model the live pattern takes the buffer content from before the write, and the new value appears only at the next strobe or boundary. Exhaustive duty sweeps over small cycle values, plus a sweep over all 64 state-select patterns, confirm the pin values in every clock.

// File: rtl/bldc_pattern_gen.sv
module bldc_pattern_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          run,
  input  logic          cmt_ext,
  input  logic          cmt_sw,
  input  logic          kill,
  output logic [5:0]    pins,
  output logic          irq
);
  localparam int NPH  = 3;
  localparam int NPIN = 2 * NPH;
  localparam logic [2:0] A_CYC = 3'd0;
  localparam logic [2:0] A_SEL = 3'd4;
  localparam logic [2:0] A_DAT = 3'd5;
  localparam logic [2:0] A_POL = 3'd6;
  localparam logic [2:0] A_IEN = 3'd7;

  logic [CW-1:0]   cnt, cyc_b, cyc_q;
  logic [CW-1:0]   duty_b [NPH];
  logic [CW-1:0]   duty_q [NPH];
  logic [NPIN-1:0] sel_b, sel_q, dat_b, dat_q, pol_q;
  logic            ien_q;
  logic [NPH-1:0]  pwm;

  wire wrap   = run && (cnt == cyc_q);
  wire commit = cmt_ext || cmt_sw;
  wire idle_w = wr_en && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_b <= '0;
      cyc_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_CYC) cyc_b <= wr_data;
      if (idle_w && wr_addr == A_CYC) cyc_q <= wr_data;
      else if (wrap)                  cyc_q <= cyc_b;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    localparam logic [2:0] A_DU = 3'(p + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_b[p] <= '0;
        duty_q[p] <= '0;
      end else begin
        if (wr_en && wr_addr == A_DU) duty_b[p] <= wr_data;
        if (idle_w && wr_addr == A_DU) duty_q[p] <= wr_data;
        else if (wrap)                 duty_q[p] <= duty_b[p];
      end
    end
    assign pwm[p] = cnt < duty_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_b <= '0;
      sel_q <= '0;
      dat_b <= '0;
      dat_q <= '0;
      pol_q <= '1;
      ien_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_SEL) sel_b <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == A_DAT) dat_b <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == A_POL) pol_q <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == A_IEN) ien_q <= wr_data[0];
      if (idle_w && wr_addr == A_SEL) sel_q <= wr_data[NPIN-1:0];
      else if (commit)                sel_q <= sel_b;
      if (idle_w && wr_addr == A_DAT) dat_q <= wr_data[NPIN-1:0];
      else if (commit)                dat_q <= dat_b;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    wire act = sel_q[i] ? dat_q[i] : pwm[i/2];
    assign pins[i] = (kill || !run) ? ~pol_q[i] : ~(act ^ pol_q[i]);
  end

  assign irq = ien_q && wrap;
endmodule

// File: rtl/bldc_pattern_gen_chk.sv
module bldc_pattern_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          kill,
  input logic          cmt_ext,
  input logic          cmt_sw,
  input logic [5:0]    pins,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cyc_q,
  input logic [5:0]    sel_q,
  input logic [5:0]    dat_q,
  input logic [5:0]    pol_q
);
  // R10
  kill_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> pins == ~pol_q);

  // R6
  stop_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pins == ~pol_q);

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == cyc_q) |=> cnt == '0);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cyc_q);

  // R7
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != cyc_q) |=> $stable(cyc_q));

  // R8
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmt_ext && !cmt_sw) |=> ($stable(sel_q) && $stable(dat_q)));

  // R9
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> cnt == '0);
endmodule

bind bldc_pattern_gen bldc_pattern_gen_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .kill(kill),
  .cmt_ext(cmt_ext), .cmt_sw(cmt_sw), .pins(pins), .irq(irq),
  .cnt(cnt), .cyc_q(cyc_q), .sel_q(sel_q), .dat_q(dat_q), .pol_q(pol_q)
);

// File: tb/bldc_pattern_gen_tb.sv
module bldc_pattern_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, run = 1'b0, cmt_ext = 1'b0, cmt_sw = 1'b0, kill = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pins;
  logic        irq;
  int tests = 0, fails = 0;

  // model state (from requirements)
  logic [15:0] m_cnt = '0, m_cyc = '0, b_cyc = '0;
  logic [15:0] m_du [3] = '{default: '0};
  logic [15:0] b_du [3] = '{default: '0};
  logic [5:0]  m_sel = '0, b_sel = '0, m_dat = '0, b_dat = '0, m_pol = '1;
  logic        m_ien = 1'b0;

  bldc_pattern_gen #(.CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .cmt_ext(cmt_ext), .cmt_sw(cmt_sw), .kill(kill), .pins(pins), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [5:0] exp_pins();
    logic [5:0] e;
    for (int i = 0; i < 6; i++) begin
      logic a;
      a = m_sel[i] ? m_dat[i] : (m_cnt < m_du[i/2]);
      e[i] = (kill || !run) ? ~m_pol[i] : (m_pol[i] ? a : ~a);
    end
    return e;
  endfunction

  task automatic compare(input string tag);
    logic [5:0] ep;
    logic ei;
    ep = exp_pins();
    ei = m_ien && run && (m_cnt == m_cyc);
    tests++;
    if (pins !== ep || irq !== ei) begin
      fails++;
      $display("FAIL %s: pins=%b irq=%b expected pins=%b irq=%b", tag, pins, irq, ep, ei);
    end
  endtask

  task automatic step(input string tag);
    logic wrap, com;
    @(posedge clk);
    wrap = run && (m_cnt == m_cyc);
    com  = cmt_ext || cmt_sw;
    if (wrap) begin
      m_cyc = b_cyc;
      for (int p = 0; p < 3; p++) m_du[p] = b_du[p];
    end
    if (com) begin m_sel = b_sel; m_dat = b_dat; end
    if (!run || wrap) m_cnt = '0; else m_cnt = m_cnt + 1'b1;
    if (wr_en) begin
      case (wr_addr)
        3'd0: begin b_cyc = wr_data; if (!run) m_cyc = wr_data; end
        3'd1, 3'd2, 3'd3: begin
          b_du[wr_addr-1] = wr_data;
          if (!run) m_du[wr_addr-1] = wr_data;
        end
        3'd4: begin b_sel = wr_data[5:0]; if (!run) m_sel = wr_data[5:0]; end
        3'd5: begin b_dat = wr_data[5:0]; if (!run) m_dat = wr_data[5:0]; end
        3'd6: m_pol = wr_data[5:0];
        default: m_ien = wr_data[0];
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");
    step("R1");

    // R5 polarity: true pins active-high, complement pins active-low (R11 addr 6)
    wr(3'd6, 16'h0015, "R5 R11");

    // R3/R2/R9 exhaustive duty sweep over small cycles
    for (int c = 1; c <= 6; c++) begin
      wr(3'd7, 16'(c % 2), "R9 R11");
      for (int d = 0; d <= c + 1; d++) begin
        int on;
        wr(3'd0, 16'(c), "R6 R11");
        wr(3'd1, 16'(d), "R6");
        wr(3'd2, 16'((d + 1) % (c + 2)), "R6");
        wr(3'd3, 16'(c + 1 - d), "R6");
        run = 1'b1;
        on = 0;
        for (int k = 0; k < 2 * (c + 1); k++) begin
          step("R3 R2 R5 R9");
          if (k < c + 1 && pins[0]) on++;
        end
        tests++;
        if (on != ((d < c + 1) ? d : c + 1)) begin
          fails++;
          $display("FAIL R3: active clocks=%0d expected=%0d", on, (d < c + 1) ? d : c + 1);
        end
        run = 1'b0;
        step("R6 stopped inactive");
      end
    end

    // R4/R8: all 64 state-select patterns committed by software strobe
    wr(3'd7, 16'd1, "R9");
    wr(3'd0, 16'd3, "R6");
    wr(3'd1, 16'd2, "R6");
    wr(3'd2, 16'd1, "R6");
    wr(3'd3, 16'd3, "R6");
    run = 1'b1;
    for (int s = 0; s < 64; s++) begin
      wr(3'd4, 16'(s), "R8 buffered only");
      wr(3'd5, 16'((s * 37) & 63), "R8 buffered only");
      step("R8 no strobe");
      cmt_sw = 1'b1;
      step("R8 sw commit");
      cmt_sw = 1'b0;
      repeat (3) step("R4");
    end

    // R8: write in the same clock as an external strobe is not committed
    wr(3'd4, 16'h0000, "R8");
    cmt_ext = 1'b1;
    step("R8 ext commit");
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h003F;
    step("R8 same-cycle write");
    wr_en = 1'b0; cmt_ext = 1'b0;
    repeat (4) step("R8 old pattern held");
    cmt_ext = 1'b1;
    step("R8 ext commit new");
    cmt_ext = 1'b0;
    wr(3'd4, 16'h0000, "R8");
    cmt_sw = 1'b1; step("R8"); cmt_sw = 1'b0;

    // R7: running cycle/duty writes wait for the boundary, incl. write on the match clock
    wr(3'd0, 16'd6, "R7");
    wr(3'd1, 16'd5, "R7");
    repeat (12) step("R7");
    for (int k = 0; k < 7; k++) begin
      if (m_cnt == m_cyc) wr(3'd1, 16'd1, "R7 write at boundary");
      else step("R7");
    end
    repeat (16) step("R7");

    // R10: kill overrides PWM and level pins
    wr(3'd4, 16'h0033, "R8");
    wr(3'd5, 16'h0021, "R8");
    cmt_sw = 1'b1; step("R8"); cmt_sw = 1'b0;
    kill = 1'b1;
    repeat (10) step("R10 kill");
    kill = 1'b0;
    repeat (4) step("R10 release");

    // R6: stopped writes go live at once, visible right after restart
    run = 1'b0;
    step("R6");
    wr(3'd4, 16'h002A, "R6 immediate");
    wr(3'd5, 16'h003C, "R6 immediate");
    wr(3'd0, 16'd2, "R6 immediate");
    run = 1'b1;
    repeat (8) step("R6 R2 restart");
    run = 1'b0;
    step("R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule